// File: doc/BRIEF.md
# Multiply-Accumulator with Load and Overflow Pulse

This block multiplies two 18-bit operands and folds the 36-bit product into a 52-bit running total held in an output register. The register feeds back into the adder, so each clock either adds or subtracts the newest product. The 16 spare bits mean that at least 2^16 full-scale products can be summed before the total can leave its range. Each operand has its own flag that says whether it is read as two's complement or as unsigned. The product is signed when either flag is set, and the add, the subtract and the range check then work in signed arithmetic.

A load control starts a new sum without a dead cycle. On the edge where the load is seen, the feedback term is taken as zero, so the register takes the product when adding, or the negated product when subtracting. Only a product can be loaded, never a constant. A one-cycle flag reports an edge on which the exact result of that step could not be held in 52 bits: above the top or below zero for unsigned sums, and beyond the signed range for signed sums.

Operands always pass through one input register. The `PIPE` parameter (0 or 1) inserts one more register between the multiplier and the adder. The operand signedness flags travel with their operands. The add/subtract and load controls pass through `CTRL_DLY` registers (0, 1 or 2). They line up with the operands presented in the same cycle when `CTRL_DLY` equals 1 + `PIPE`.

Top module: `mac_acc52`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_out` becomes 0 and `ovf` becomes 0 on that edge.
- R2: With `add_en` = 1 and `load` = 0 at the adder stage, the new `acc_out` is the old `acc_out` plus the product, modulo 2^52.
- R3: With `add_en` = 0 and `load` = 0 at the adder stage, the new `acc_out` is the old `acc_out` minus the product, modulo 2^52.
- R4: An operand whose flag (`a_signed` for `op_a`, `b_signed` for `op_b`) is 1 is read as 18-bit two's complement; with the flag at 0 it is read as unsigned. The product is exact and is sign-extended to 52 bits.
- R5: With `load` = 1 at the adder stage, the feedback term is zero. The new `acc_out` is the product when `add_en` = 1 and its negation when `add_en` = 0, and the following edge accumulates normally with no dead cycle.
- R6: When both operand flags are 0, `ovf` is 1 after an edge whose exact result is at least 2^52 or below zero, and 0 otherwise.
- R7: When either operand flag is 1, `ovf` is 1 after an edge whose exact signed result lies outside [-2^51, 2^51-1], and 0 otherwise.
- R8: `ovf` is a pulse and not a sticky bit: it returns to 0 after the next edge whose step stays in range.
- R9: Operands presented before rising edge e affect `acc_out` and `ovf` right after edge e+1+`PIPE`.
- R10: Controls presented before rising edge e act at edge e+`CTRL_DLY`; with `CTRL_DLY` = 0 they act at edge e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 18 | First operand |
| op_b | input | 18 | Second operand |
| a_signed | input | 1 | 1: `op_a` is two's complement |
| b_signed | input | 1 | 1: `op_b` is two's complement |
| add_en | input | 1 | 1: add the product, 0: subtract it |
| load | input | 1 | 1: take the feedback term as zero on this step |
| acc_out | output | 52 | Registered running total |
| ovf | output | 1 | One-cycle range-loss flag |

## Verification
An operand pair presented before edge e appears in `acc_out` and `ovf` after edge e+1+`PIPE`. A control value presented before edge e acts at edge e+`CTRL_DLY`. The bench keeps a history of everything it drove and, for each step, picks the operand entry 1+`PIPE` edges back and the control entry `CTRL_DLY` edges back, so the two latencies are handled separately. After each rising edge it compares both outputs on the following falling edge. It does this for two instances at once: one with the default parameters and one with `PIPE` = 1 and `CTRL_DLY` = 2.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int A_W    = 18;
    localparam int B_W    = 18;
    localparam int ACC_W  = 52;
    localparam int PROD_W = A_W + B_W + 2;   // sign-extended operand product
    localparam int GUARD  = ACC_W - PROD_W;
    localparam int MSB    = ACC_W - 1;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic           a_sgn;
        logic           b_sgn;
    } opnd_t;

    typedef struct packed {
        logic add;
        logic load;
    } ctrl_t;

    typedef struct packed {
        logic [ACC_W-1:0] val;
        logic             sgn;
    } prod_t;

    typedef struct packed {
        logic [ACC_W-1:0] val;
        logic             ovf;
    } step_t;

    // Exact product, each operand widened by one bit according to its flag.
    function automatic logic [ACC_W-1:0] full_product(opnd_t o);
        logic signed [A_W:0]      ea;
        logic signed [B_W:0]      eb;
        logic signed [PROD_W-1:0] pr;
        ea = {o.a_sgn & o.a[A_W-1], o.a};
        eb = {o.b_sgn & o.b[B_W-1], o.b};
        pr = ea * eb;
        return {{GUARD{pr[PROD_W-1]}}, pr};
    endfunction

    // One accumulation step with range check.
    function automatic step_t acc_step(logic [ACC_W-1:0] fb, logic [ACC_W-1:0] p,
                                       logic sgn, logic add);
        logic [ACC_W:0] s;
        step_t r;
        if (add) s = {1'b0, fb} + {1'b0, p};
        else     s = {1'b0, fb} - {1'b0, p};
        r.val = s[ACC_W-1:0];
        if (sgn) begin
            if (add) r.ovf = (fb[MSB] == p[MSB]) && (r.val[MSB] != fb[MSB]);
            else     r.ovf = (fb[MSB] != p[MSB]) && (r.val[MSB] != fb[MSB]);
        end else begin
            r.ovf = s[ACC_W];   // carry on add, borrow on subtract
        end
        return r;
    endfunction
endpackage

// File: rtl/mac_dly.sv
module mac_dly #(
    parameter int N = 1,
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (N == 0) begin : g_pass
            logic unused_clk_rst;
            assign unused_clk_rst = clk ^ rst;
            assign q = d;
        end else begin : g_regs
            logic [W-1:0] stage [N];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < N; i++) stage[i] <= '0;
                end else begin
                    stage[0] <= d;
                    for (int i = 1; i < N; i++) stage[i] <= stage[i-1];
                end
            end
            assign q = stage[N-1];
        end
    endgenerate
endmodule

// File: rtl/mac_mult.sv
module mac_mult
    import mac_pkg::*;
(
    input  opnd_t o,
    output prod_t p
);
    always_comb begin
        p.val = full_product(o);
        p.sgn = o.a_sgn | o.b_sgn;
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  prod_t            p,
    input  ctrl_t            c,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);
    logic [ACC_W-1:0] fb;
    step_t            nxt;

    always_comb begin
        fb  = c.load ? '0 : acc;
        nxt = acc_step(fb, p.val, p.sgn, c.add);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
            ovf <= 1'b0;
        end else begin
            acc <= nxt.val;
            ovf <= nxt.ovf;
        end
    end
endmodule

// File: rtl/mac_acc52.sv
module mac_acc52
    import mac_pkg::*;
#(
    parameter int PIPE     = 0,
    parameter int CTRL_DLY = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [A_W-1:0]   op_a,
    input  logic [B_W-1:0]   op_b,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             add_en,
    input  logic             load,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf
);
    localparam int OPW  = $bits(opnd_t);
    localparam int PRW  = $bits(prod_t);
    localparam int CTW  = $bits(ctrl_t);

    opnd_t opnd_in, opnd_q;
    prod_t prod_raw, prod_q;
    ctrl_t ctl_in, ctl_q;

    assign opnd_in = '{a: op_a, b: op_b, a_sgn: a_signed, b_sgn: b_signed};
    assign ctl_in  = '{add: add_en, load: load};

    mac_dly #(.N(1), .W(OPW)) u_inreg (
        .clk(clk), .rst(rst), .d(opnd_in), .q(opnd_q)
    );

    mac_mult u_mult (.o(opnd_q), .p(prod_raw));

    mac_dly #(.N(PIPE), .W(PRW)) u_pipe (
        .clk(clk), .rst(rst), .d(prod_raw), .q(prod_q)
    );

    mac_dly #(.N(CTRL_DLY), .W(CTW)) u_ctl (
        .clk(clk), .rst(rst), .d(ctl_in), .q(ctl_q)
    );

    mac_accum u_acc (
        .clk(clk), .rst(rst), .p(prod_q), .c(ctl_q),
        .acc(acc_out), .ovf(ovf)
    );
endmodule

// File: rtl/mac_acc52_chk.sv
module mac_acc52_chk (
    input logic        clk,
    input logic        rst,
    input logic [51:0] acc,
    input logic        ovf,
    input logic [51:0] p,
    input logic        sgn,
    input logic        add,
    input logic        ld
);
    logic rst_d = 1'b0;
    always @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_R1: assert (acc == 52'd0 && !ovf)
                else $error("R1: outputs not cleared by reset");
        end
    end

    assert_add_R2: assert property (@(posedge clk) disable iff (rst)
        (!ld && add) |=> acc == 52'($past(acc) + $past(p)));

    assert_sub_R3: assert property (@(posedge clk) disable iff (rst)
        (!ld && !add) |=> acc == 52'($past(acc) - $past(p)));

    assert_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld |=> acc == ($past(add) ? $past(p) : 52'(52'd0 - $past(p))));

    assert_uns_carry_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && add && !sgn) |=> ovf == (acc < $past(acc)));

    assert_uns_borrow_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && !add && !sgn) |=> ovf == (acc > $past(acc)));

    assert_sgn_ovf_R7: assert property (@(posedge clk) disable iff (rst)
        (!ld && add && sgn && !p[51]) |=> ovf == ($signed(acc) < $signed($past(acc))));
endmodule

bind mac_acc52 mac_acc52_chk u_chk (
    .clk(clk), .rst(rst), .acc(acc_out), .ovf(ovf),
    .p(prod_q.val), .sgn(prod_q.sgn), .add(ctl_q.add), .ld(ctl_q.load)
);

// File: tb/tb_mac_acc52.sv
module tb_mac_acc52;
    localparam longint TWO51 = 64'sd1 <<< 51;
    localparam longint TWO52 = 64'sd1 <<< 52;

    typedef struct {
        logic [17:0] a;
        logic [17:0] b;
        bit sa, sb, ad, ld;
    } stim_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [17:0] op_a = '0, op_b = '0;
    logic        a_signed = 0, b_signed = 0, add_en = 0, load = 0;
    logic [51:0] acc0, acc1;
    logic        ovf0, ovf1;

    int n_tests = 0;
    int n_fail  = 0;
    int n_ovf   = 0;
    string cur_req = "R1";

    stim_t  hist[$];
    longint mdl_acc [2];
    bit     mdl_ovf [2];

    always #10 clk = ~clk;   // 50 MHz

    mac_acc52 dut (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed),
        .add_en(add_en), .load(load), .acc_out(acc0), .ovf(ovf0)
    );

    mac_acc52 #(.PIPE(1), .CTRL_DLY(2)) dut_pipe (
        .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
        .a_signed(a_signed), .b_signed(b_signed),
        .add_en(add_en), .load(load), .acc_out(acc1), .ovf(ovf1)
    );

    function automatic void mstep(int k, int lat, int dly);
        stim_t z, op, ct;
        longint pa, pb, p, fb, res;
        bit sg;
        z  = '{a: 0, b: 0, sa: 0, sb: 0, ad: 0, ld: 0};
        op = (hist.size() > lat) ? hist[lat] : z;
        ct = (hist.size() > dly) ? hist[dly] : z;
        pa = op.sa ? longint'($signed(op.a)) : longint'(op.a);
        pb = op.sb ? longint'($signed(op.b)) : longint'(op.b);
        p  = pa * pb;
        sg = op.sa | op.sb;
        fb = ct.ld ? 64'sd0 : mdl_acc[k];
        if (sg && fb >= TWO51) fb = fb - TWO52;
        res = ct.ad ? fb + p : fb - p;
        mdl_ovf[k] = sg ? (res >= TWO51 || res < -TWO51) : (res >= TWO52 || res < 0);
        mdl_acc[k] = res & (TWO52 - 1);
    endfunction

    task automatic compare();
        n_tests++;
        if (acc0 !== mdl_acc[0][51:0] || ovf0 !== mdl_ovf[0]) begin
            n_fail++;
            $display("FAIL %s default instance: acc=%h ovf=%b expected acc=%h ovf=%b",
                     cur_req, acc0, ovf0, mdl_acc[0][51:0], mdl_ovf[0]);
        end
        n_tests++;
        if (acc1 !== mdl_acc[1][51:0] || ovf1 !== mdl_ovf[1]) begin
            n_fail++;
            $display("FAIL %s (R9 R10 pipelined instance): acc=%h ovf=%b expected acc=%h ovf=%b",
                     cur_req, acc1, ovf1, mdl_acc[1][51:0], mdl_ovf[1]);
        end
        if (ovf0) n_ovf++;
    endtask

    task automatic cyc(input logic [17:0] a, input logic [17:0] b,
                       input bit sa, input bit sb, input bit ad, input bit ld);
        stim_t s;
        op_a = a; op_b = b; a_signed = sa; b_signed = sb; add_en = ad; load = ld;
        s = '{a: a, b: b, sa: sa, sb: sb, ad: ad, ld: ld};
        @(posedge clk);
        hist.push_front(s);
        if (hist.size() > 4) void'(hist.pop_back());
        mstep(0, 1, 1);
        mstep(1, 2, 2);
        @(negedge clk);
        compare();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        op_a = '0; op_b = '0; a_signed = 0; b_signed = 0; add_en = 0; load = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        hist.delete();
        for (int k = 0; k < 2; k++) begin mdl_acc[k] = 0; mdl_ovf[k] = 0; end
        cur_req = "R1";
        compare();
        rst = 1'b0;
    endtask

    task automatic expect_bit(input string req, input bit got, input bit exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R2: unsigned additions, starting with a load
        cur_req = "R2";
        cyc(18'd3, 18'd7, 0, 0, 1, 1);
        cyc(18'd100, 18'd200, 0, 0, 1, 0);
        cyc(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0);
        cyc(18'd0, 18'd5, 0, 0, 1, 0);
        repeat (3) cyc(18'd0, 18'd0, 0, 0, 1, 0);

        // R3: subtraction that stays non-negative
        cur_req = "R3";
        cyc(18'd10, 18'd10, 0, 0, 0, 0);
        cyc(18'd1, 18'd1, 0, 0, 0, 0);
        repeat (3) cyc(18'd0, 18'd0, 0, 0, 1, 0);

        // R4: signedness combinations on the same bit pattern
        cur_req = "R4";
        cyc(18'h3FFFD, 18'd5, 1, 0, 1, 1);     // -3 * 5
        cyc(18'h3FFFD, 18'd5, 0, 0, 1, 1);     // unsigned bit pattern
        cyc(18'd5, 18'h3FFFD, 0, 1, 1, 1);     // 5 * -3
        cyc(18'h20000, 18'h20000, 1, 1, 1, 1); // -2^17 * -2^17
        cyc(18'h20000, 18'h3FFFF, 1, 0, 0, 0); // minus (-2^17 * (2^18-1))
        repeat (3) cyc(18'd0, 18'd0, 1, 1, 1, 0);

        // R5: back-to-back loads, subtract-load, then continued accumulation
        cur_req = "R5";
        cyc(18'd9, 18'd9, 0, 0, 1, 1);
        cyc(18'd4, 18'd4, 0, 0, 1, 1);
        cyc(18'd2, 18'd3, 1, 1, 0, 1);
        cyc(18'd1, 18'd1, 1, 1, 1, 0);
        cyc(18'd7, 18'd6, 1, 1, 1, 1);
        cyc(18'd7, 18'd6, 1, 1, 1, 0);
        repeat (3) cyc(18'd0, 18'd0, 1, 1, 1, 0);

        // R6: unsigned borrow below zero, then carry past the top
        do_reset();
        cur_req = "R6";
        n_ovf = 0;
        cyc(18'd1, 18'd1, 0, 0, 0, 0);
        repeat (3) cyc(18'd0, 18'd0, 0, 0, 1, 0);
        expect_bit("R6 borrow flagged", n_ovf > 0, 1'b1);
        n_ovf = 0;
        cyc(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 1);
        repeat (65600) cyc(18'h3FFFF, 18'h3FFFF, 0, 0, 1, 0);
        // R8: after the wrap the next in-range steps drop the flag
        cur_req = "R8";
        repeat (3) cyc(18'd0, 18'd0, 0, 0, 1, 0);
        expect_bit("R6 carry flagged", n_ovf > 0, 1'b1);
        expect_bit("R8 flag cleared after wrap", ovf0, 1'b0);

        // R7: signed overflow by repeated subtraction of a negative product
        do_reset();
        cur_req = "R7";
        n_ovf = 0;
        cyc(18'h20000, 18'h3FFFF, 1, 0, 0, 1);
        repeat (65600) cyc(18'h20000, 18'h3FFFF, 1, 0, 0, 0);
        cur_req = "R8";
        repeat (3) cyc(18'd0, 18'd0, 1, 0, 1, 0);
        expect_bit("R7 signed overflow flagged", n_ovf > 0, 1'b1);
        expect_bit("R8 flag cleared after signed wrap", ovf0, 1'b0);

        // R9 / R10: mixed random traffic against both latency settings
        do_reset();
        cur_req = "R9";
        for (int i = 0; i < 3000; i++) begin
            logic [17:0] ra, rb;
            bit rsa, rsb, rad, rld;
            ra  = 18'($urandom);
            rb  = 18'($urandom);
            rsa = bit'($urandom_range(0, 1));
            rsb = bit'($urandom_range(0, 1));
            rad = bit'($urandom_range(0, 1));
            rld = ($urandom_range(0, 7) == 0);
            if (i == 1500) cur_req = "R10";
            cyc(ra, rb, rsa, rsb, rad, rld);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule